// File: doc/BRIEF.md
# Hiccup protection and power-good sequencer

This block is the digital supervisor of a two-phase buck regulator controller. It takes the outputs of the analog comparators: supply level, enable-divider level, per-channel overcurrent, overvoltage, the power-good window, and the two soft-start node levels. It also takes a per-channel flag that says a companion driver is present. From these it drives the soft-start charge and discharge switches, a mode for each PWM pin (run, forced low, high impedance), an active-high power-good flag and a latched-off status. The power-good flag is low when the open-drain pin pulls down.

Every comparator flag passes through a two-flop synchronizer and then a glitch filter of `FILT` cycles before the state machine uses it. After power-on the sequencer samples which channels have a driver. It then runs soft start and enters regulation once the output sits inside the power-good window. An overcurrent starts a hiccup cycle: the PWM pins float, the sequencer waits for the soft-start node to fall below 90 percent of supply, discharges the node to 0.2 V, and then restarts soft start. The third overcurrent latches the converter off. An overvoltage latches the converter off with the PWM pins held low. Only a new power-on clears either latch.

Top module: `hiccup_seq`

## Requirements
- R1: While the filtered supply flag or enable flag is low, and during rst_n, the block is in reset. In that state every pwm_mode field is high impedance (2'b00), ss_charge=0, ss_discharge=1, pwr_good=0 and latched_off=0. A fall of either flag returns the block to this state from any state.
- R2: On leaving reset, each channel's drv_present bit is captured once. A channel whose bit was 0 keeps pwm_mode 2'b00 until the next reset. Later changes of drv_present have no effect until then.
- R3: After reset is released, soft start runs with ss_charge=1 and ss_discharge=0. Every enabled channel is in run mode (2'b10) and pwr_good=0.
- R4: Soft start ends when in_window is high. The block then enters regulation, where ss_charge stays 1, enabled channels stay in run mode and pwr_good follows in_window.
- R5: In soft start or regulation, an overcurrent flag on an enabled channel counts a strike. When it is not the third strike, it sets every channel to high impedance with ss_charge=0 and ss_discharge=0. Overcurrent on a channel without a driver is ignored.
- R6: During a hiccup, ss_discharge rises only once ss_below_hi is high. When ss_below_lo is then high, soft start restarts (ss_charge=1, discharge off). ss_charge and ss_discharge are never both 1.
- R7: The third overcurrent since reset sets latched_off=1 with all channels in high impedance and ss_discharge=1. Only a reset clears this state. Reset also clears the strike count, so the first overcurrent after a reset starts a hiccup and does not latch.
- R8: In any state other than reset, ov_trip sets latched_off=1 and every pwm_mode to forced low (2'b01), and only a reset clears this. When ov_trip and overcurrent arrive in the same cycle, the overvoltage outcome wins.
- R9: pwr_good is 1 only in regulation while in_window is 1. It is 0 in soft start, in every fault state and in reset.
- R10: A comparator pulse that lasts one clock cycle is filtered out and has no effect. A level held for at least FILT+1 cycles is acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its power-on threshold |
| enable_ok | input | 1 | Enable divider above its trip level |
| oc | input | NCH | Per-channel overcurrent flag |
| ov_trip | input | 1 | Output above the overvoltage limit |
| in_window | input | 1 | Output inside the power-good band |
| ss_below_hi | input | 1 | Soft-start node below 90 percent of supply |
| ss_below_lo | input | 1 | Soft-start node below 0.2 V |
| drv_present | input | NCH | Per-channel driver detected on the PWM pin |
| ss_charge | output | 1 | Enable the soft-start charge current |
| ss_discharge | output | 1 | Enable the soft-start discharge current |
| pwm_mode | output | 2*NCH | Per-channel mode: 00 high impedance, 01 forced low, 10 run |
| pwr_good | output | 1 | High when output is good (pin released) |
| latched_off | output | 1 | Converter latched off by a fault |

## Verification
Overvoltage and overcurrent can reach the state machine in the same cycle, and the block must then take the overvoltage path. The bench raises ov_trip and an overcurrent flag on the same clock during regulation. Because both flags pass through identical synchronizer and filter stages, they arrive together. The result is correct only if every PWM field reads forced low and latched_off is set; a float-and-hiccup outcome counts as a mismatch.

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int NCH     = 2,
  parameter int FILT    = 2,
  parameter int STRIKES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             enable_ok,
  input  logic [NCH-1:0]   oc,
  input  logic             ov_trip,
  input  logic             in_window,
  input  logic             ss_below_hi,
  input  logic             ss_below_lo,
  input  logic [NCH-1:0]   drv_present,
  output logic             ss_charge,
  output logic             ss_discharge,
  output logic [2*NCH-1:0] pwm_mode,
  output logic             pwr_good,
  output logic             latched_off
);
  localparam int NIN = 2*NCH + 6;
  localparam int CW  = $clog2(FILT) + 1;
  localparam int SW  = $clog2(STRIKES + 1);
  localparam logic [1:0] M_HIZ = 2'b00, M_LOW = 2'b01, M_RUN = 2'b10;

  typedef enum logic [2:0] {S_POR, S_SOFT, S_RUN, S_WAIT, S_DRAIN, S_OCOFF, S_OVOFF} st_t;

  logic [NIN-1:0] raw, s1, s2, flt;
  assign raw = {drv_present, oc, supply_ok, enable_ok, ov_trip, in_window, ss_below_hi, ss_below_lo};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar i = 0; i < NIN; i++) begin : g_filt
    logic [CW-1:0] cnt;
    logic          f;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (s2[i] == f) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT-1)) begin
        f   <= s2[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    assign flt[i] = f;
  end

  logic           f_blo, f_bhi, f_win, f_ov, por_ok;
  logic [NCH-1:0] f_oc, f_drv;
  assign f_blo  = flt[0];
  assign f_bhi  = flt[1];
  assign f_win  = flt[2];
  assign f_ov   = flt[3];
  assign por_ok = flt[4] & flt[5];
  assign f_oc   = flt[6 +: NCH];
  assign f_drv  = flt[6+NCH +: NCH];

  st_t            state;
  logic [SW-1:0]  strikes;
  logic [NCH-1:0] chan_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_POR;
      strikes <= '0;
      chan_en <= '0;
    end else if (!por_ok) begin
      state   <= S_POR;
      strikes <= '0;
    end else if (state == S_POR) begin
      chan_en <= f_drv;
      state   <= S_SOFT;
    end else if (state != S_OVOFF && f_ov) begin
      state <= S_OVOFF;
    end else begin
      case (state)
        S_SOFT, S_RUN:
          if (|(f_oc & chan_en)) begin
            strikes <= strikes + SW'(1);
            state   <= (strikes == SW'(STRIKES-1)) ? S_OCOFF : S_WAIT;
          end else if (state == S_SOFT && f_win) begin
            state <= S_RUN;
          end
        S_WAIT:  if (f_bhi) state <= S_DRAIN;
        S_DRAIN: if (f_blo) state <= S_SOFT;
        default: ;
      endcase
    end

  assign ss_charge    = (state == S_SOFT) || (state == S_RUN);
  assign ss_discharge = (state == S_POR) || (state == S_DRAIN) ||
                        (state == S_OCOFF) || (state == S_OVOFF);
  assign latched_off  = (state == S_OCOFF) || (state == S_OVOFF);
  assign pwr_good     = (state == S_RUN) && f_win;

  for (genvar c = 0; c < NCH; c++) begin : g_pwm
    assign pwm_mode[2*c +: 2] = (state == S_OVOFF)           ? M_LOW :
                                (ss_charge && chan_en[c])    ? M_RUN : M_HIZ;
  end
endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss_charge,
  input logic             ss_discharge,
  input logic [2*NCH-1:0] pwm_mode,
  input logic             pwr_good,
  input logic             latched_off
);
  localparam logic [2*NCH-1:0] ALL_LOW = {NCH{2'b01}};
  localparam logic [2*NCH-1:0] ALL_HIZ = '0;

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_charge && ss_discharge));

  assert_latch_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> ss_discharge && (pwm_mode == ALL_LOW || pwm_mode == ALL_HIZ));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |=> (latched_off || (pwm_mode == ALL_HIZ && ss_discharge)));

  assert_low_only_ov_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode == ALL_LOW) |-> latched_off);

  assert_pg_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> ss_charge && !latched_off);

  assert_hiccup_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_charge && !ss_discharge) |-> pwm_mode == ALL_HIZ && !pwr_good && !latched_off);
endmodule

bind hiccup_seq hiccup_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_charge(ss_charge), .ss_discharge(ss_discharge),
  .pwm_mode(pwm_mode), .pwr_good(pwr_good), .latched_off(latched_off)
);

// File: tb/sim_hiccup_seq.sv
`timescale 1ns/1ps
module sim_hiccup_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, enable_ok = 0, ov_trip = 0, in_window = 0, ss_below_hi = 0, ss_below_lo = 0;
  logic [1:0] oc = 2'b00, drv_present = 2'b11;
  logic ss_charge, ss_discharge, pwr_good, latched_off;
  logic [3:0] pwm_mode;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hiccup_seq u0 (.clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable_ok(enable_ok),
    .oc(oc), .ov_trip(ov_trip), .in_window(in_window), .ss_below_hi(ss_below_hi),
    .ss_below_lo(ss_below_lo), .drv_present(drv_present), .ss_charge(ss_charge),
    .ss_discharge(ss_discharge), .pwm_mode(pwm_mode), .pwr_good(pwr_good),
    .latched_off(latched_off));

  // in: {supply, enable, oc1, oc0, ov, window, below_hi, below_lo}
  // exp: {charge, discharge, pwm1, pwm0, pgood, latched}
  localparam int NV = 21;
  localparam logic [15:0] VEC [0:NV-1] = '{
    {8'b00000000, 8'b01000000}, {8'b11000000, 8'b10101000}, {8'b11000100, 8'b10101010},
    {8'b11000000, 8'b10101000}, {8'b11010100, 8'b00000000}, {8'b11000110, 8'b01000000},
    {8'b11000011, 8'b10101000}, {8'b11000100, 8'b10101010}, {8'b11100100, 8'b00000000},
    {8'b11000111, 8'b10101010}, {8'b11110100, 8'b01000001}, {8'b11000111, 8'b01000001},
    {8'b01000000, 8'b01000000}, {8'b11000100, 8'b10101010}, {8'b11010100, 8'b00000000},
    {8'b11001100, 8'b01010101}, {8'b11000100, 8'b01010101}, {8'b10000100, 8'b01000000},
    {8'b11000100, 8'b10101010}, {8'b11011100, 8'b01010101}, {8'b00000000, 8'b01000000}};
  localparam string TAG [0:NV-1] = '{"R1", "R3", "R4", "R9", "R5", "R6", "R6", "R4", "R5",
    "R6", "R7", "R7", "R1", "R4", "R7", "R8", "R8", "R8", "R4", "R8", "R1"};

  function automatic logic [7:0] outs();
    return {ss_charge, ss_discharge, pwm_mode, pwr_good, latched_off};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic apply(logic [7:0] v);
    {supply_ok, enable_ok, oc, ov_trip, in_window, ss_below_hi, ss_below_lo} = v;
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 8'b01000000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:8]);
      settle();
      check(TAG[i], outs(), VEC[i][7:0]);
    end

    // R2: only channel 0 has a driver
    drv_present = 2'b01;
    apply(8'b11000000);
    settle();
    check("R2", outs(), 8'b10001000);
    drv_present = 2'b11;
    settle();
    check("R2", outs(), 8'b10001000);
    // R5: overcurrent on the channel without driver is ignored
    apply(8'b11100000);
    settle();
    check("R5", outs(), 8'b10001000);
    apply(8'b00000000);
    settle();
    apply(8'b11000100);
    settle();
    check("R2", outs(), 8'b10101010);

    // R10: one-cycle glitch is filtered, a held level acts
    @(negedge clk) oc = 2'b01;
    @(negedge clk) oc = 2'b00;
    settle();
    check("R10", outs(), 8'b10101010);
    @(negedge clk) oc = 2'b01;
    repeat (3) @(negedge clk);
    oc = 2'b00;
    settle();
    check("R10", outs(), 8'b00000000);

    // R1: mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", outs(), 8'b01000000);
    rst_n = 1'b1;
    settle();
    check("R3", outs(), 8'b10101010);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule